// File: doc/BRIEF.md
# Run-Time Configurable Multi-Chip Register Remapper

This block sits between an 8-bit host bus and a bank of up to 32 identical sound-chip register files. Every host access that falls in a 1 KiB window at $D400–$D7FF is turned into a one-hot chip select and a 5-bit register index. On a read, the block returns the byte from the selected chip. The mapping from host address to (chip, register) is chosen by a mode register that software writes. The modes are:

- **Linear:** each chip owns a contiguous 32-byte block.
- **Interleaved:** the copies of one register from all chips are gathered together.
- **Voice-oriented:** the same register of consecutive voices sits one address apart, across 8 chips and 24 voices.

Each chip has 32 slots, but only indices 0–28 are real registers. The three voices of a chip use 7-register groups at indices 0, 7 and 14. Indices 21–28 are per-chip shared registers. The mode register sits at the last byte of the window, which no mode maps to a chip. A change of mode applies from the next bus cycle. Every access completes in the cycle it is presented: `bus_valid` has no companion ready, the block never applies back-pressure, and all outputs are combinational from the bus and the stored mode.

Top module: `multi_chip_remap`

## Requirements
- R1: After reset the mode is linear, and a read of $D7FF returns $00.
- R2: Linear mode (code 0): offset o = addr − $D400 selects chip o/32 and register o%32.
- R3: Interleaved mode (code 1): offset o selects register o/32 of chip o%32.
- R4: Voice mode (code 2), offsets 0–167: offset 24·j + v selects chip v/3 and register 7·(v%3) + j, for j in 0–6 and v in 0–23.
- R5: Voice mode, offsets 168–231: offset 168 + 8·k + c selects chip c and register 21 + k, for k and c in 0–7. Offsets 232 and above select nothing.
- R6: A slot whose register index is 29–31, or whose chip lies beyond the mapped chips, asserts no chip select and leaves `chip_we` low. A read of such a slot returns $FF, and `chip_reg` is 0.
- R7: A write to $D7FF stores `bus_wdata[1:0]` as the mode. The new mode governs accesses from the next cycle on. A read of $D7FF returns {6'b0, mode}. The control access itself selects no chip.
- R8: Mode code 3 maps exactly like linear mode.
- R9: Accesses outside $D400–$D7FF select no chip and read $FF.
- R10: During a mapped access, `chip_we` equals `bus_we`, `chip_wdata` equals `bus_wdata`, and `bus_rdata` equals the selected chip's byte.
- R11: In every mode, each legal (chip, register) pair is reached by exactly one address in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| chip_sel | output | NCHIP | One-hot chip select |
| chip_we | output | 1 | Write strobe to the selected chip |
| chip_reg | output | 5 | Register index within the selected chip |
| chip_wdata | output | 8 | Write data to the chips |
| chip_rdata | input | NCHIP*8 | Read bytes of all chips, chip n at bits 8n+7:8n |

## Verification
Two functions can fall in the same cycle boundary: a mode write to $D7FF, and a data access that must be decoded under a mode. The bench writes the mode and presents a data access in the very next cycle. The reference model switches its mode at that same edge, so every access right after a mode change is judged against the new layout. The bench also checks that the control-write cycle itself drives no chip select. Full 1024-offset sweeps in each of the four mode codes then confirm that each (chip, register) pair appears exactly once.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    MAP_LINEAR = 2'd0,
    MAP_INTLV  = 2'd1,
    MAP_VOICE  = 2'd2,
    MAP_RSVD   = 2'd3
  } map_mode_e;

  localparam logic [9:0] CTRL_OFF  = 10'h3FF;
  localparam int         REG_LAST  = 28;
  localparam int         VOICE_REGS = 7;
  localparam int         SHARED_REGS = 8;
  localparam int         SHARED_IDX0 = 21;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr,
  input  logic [1:0] wr_code,
  output map_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MAP_LINEAR;
    else if (ctrl_wr) mode_q <= map_mode_e'(wr_code);
  end

  // R7: a control write becomes the stored mode at the next edge
  a_r7_ctrl_update: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (mode_q == map_mode_e'($past(wr_code))));

  // R7: without a control write the mode never moves
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(mode_q));
endmodule

// File: rtl/remap_decode.sv
module remap_decode
  import remap_pkg::*;
#(
  parameter int NCHIP = 32,
  parameter int VCHIP = 8,
  localparam int CW   = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  map_mode_e        mode_q,
  input  logic             acc,
  input  logic [9:0]       off,
  output logic [NCHIP-1:0] sel,
  output logic [4:0]       reg_idx,
  output logic [CW-1:0]    chip_idx,
  output logic             hit
);
  localparam logic [9:0] VOICES_L = 10'(3 * VCHIP);
  localparam logic [9:0] SH_BASE  = 10'(VOICE_REGS * 3 * VCHIP);
  localparam logic [9:0] SH_END   = 10'(VOICE_REGS * 3 * VCHIP + SHARED_REGS * VCHIP);
  localparam logic [9:0] VCHIP_L  = 10'(VCHIP);
  localparam logic [9:0] NCHIP_L  = 10'(NCHIP);

  logic [9:0] c_w, r_w, v_w, s_w;
  logic       in_map;

  always_comb begin
    c_w    = '0;
    r_w    = '0;
    v_w    = '0;
    s_w    = '0;
    in_map = 1'b1;
    unique case (mode_q)
      MAP_INTLV: begin
        r_w = {5'd0, off[9:5]};
        c_w = {5'd0, off[4:0]};
      end
      MAP_VOICE: begin
        if (off < SH_BASE) begin
          v_w = off % VOICES_L;
          c_w = v_w / 10'd3;
          r_w = (v_w % 10'd3) * 10'(VOICE_REGS) + off / VOICES_L;
        end else if (off < SH_END) begin
          s_w = off - SH_BASE;
          c_w = s_w % VCHIP_L;
          r_w = 10'(SHARED_IDX0) + s_w / VCHIP_L;
        end else begin
          in_map = 1'b0;
        end
      end
      default: begin
        c_w = {5'd0, off[9:5]};
        r_w = {5'd0, off[4:0]};
      end
    endcase
  end

  assign hit      = acc && in_map && (r_w <= 10'(REG_LAST)) && (c_w < NCHIP_L);
  assign reg_idx  = hit ? r_w[4:0] : 5'd0;
  assign chip_idx = hit ? c_w[CW-1:0] : '0;

  for (genvar g = 0; g < NCHIP; g++) begin : g_sel
    assign sel[g] = hit && (c_w == 10'(g));
  end

  // R6: in linear layout, slot indices 29..31 never reach a chip
  a_r6_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mode_q == MAP_LINEAR) && (off[4:0] > 5'd28)) |-> (sel == '0));

  // R5: beyond the shared area, voice mode selects nothing
  a_r5_voice_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mode_q == MAP_VOICE) && (off >= SH_END)) |-> (sel == '0));
endmodule

// File: rtl/remap_rdmux.sv
module remap_rdmux
  import remap_pkg::*;
#(
  parameter int NCHIP = 32,
  localparam int CW   = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic [NCHIP*8-1:0] chip_rdata,
  input  logic               hit,
  input  logic [CW-1:0]      chip_idx,
  input  logic               ctrl_acc,
  input  map_mode_e          mode_q,
  output logic [7:0]         rdata
);
  always_comb begin
    if (hit)           rdata = chip_rdata[chip_idx*8 +: 8];
    else if (ctrl_acc) rdata = {6'd0, mode_q};
    else               rdata = 8'hFF;
  end
endmodule

// File: rtl/multi_chip_remap.sv
module multi_chip_remap
  import remap_pkg::*;
#(
  parameter int              NCHIP = 32,
  parameter int              VCHIP = 8,
  parameter logic [15:0]     BASE  = 16'hD400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_we,
  input  logic [15:0]        bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NCHIP-1:0]   chip_sel,
  output logic               chip_we,
  output logic [4:0]         chip_reg,
  output logic [7:0]         chip_wdata,
  input  logic [NCHIP*8-1:0] chip_rdata
);
  localparam int CW = (NCHIP > 1) ? $clog2(NCHIP) : 1;

  logic          in_win, ctrl_acc, ctrl_wr, data_acc, hit;
  logic [9:0]    off;
  logic [CW-1:0] chip_idx;
  map_mode_e     mode_q;

  assign in_win   = bus_valid && (bus_addr[15:10] == BASE[15:10]);
  assign off      = bus_addr[9:0];
  assign ctrl_acc = in_win && (off == CTRL_OFF);
  assign ctrl_wr  = ctrl_acc && bus_we;
  assign data_acc = in_win && !ctrl_acc;

  remap_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .wr_code (bus_wdata[1:0]),
    .mode_q  (mode_q)
  );

  remap_decode #(.NCHIP(NCHIP), .VCHIP(VCHIP)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .acc      (data_acc),
    .off      (off),
    .sel      (chip_sel),
    .reg_idx  (chip_reg),
    .chip_idx (chip_idx),
    .hit      (hit)
  );

  remap_rdmux #(.NCHIP(NCHIP)) u_rd (
    .chip_rdata (chip_rdata),
    .hit        (hit),
    .chip_idx   (chip_idx),
    .ctrl_acc   (ctrl_acc),
    .mode_q     (mode_q),
    .rdata      (bus_rdata)
  );

  assign chip_we    = hit && bus_we;
  assign chip_wdata = bus_wdata;

  // R10: a chip write strobe always goes to exactly one chip
  a_r10_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    chip_we |-> $onehot(chip_sel));

  // R9: traffic outside the window reaches no chip and reads $FF
  a_r9_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_addr[15:10] != BASE[15:10])) |-> ((chip_sel == '0) && (bus_rdata == 8'hFF)));

  // R7: the control slot is never forwarded to a chip
  a_r7_ctrl_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_addr == (BASE | 16'h03FF))) |-> (chip_sel == '0));
endmodule

// File: tb/multi_chip_remap_tb.sv
module multi_chip_remap_tb;
  localparam int NCHIP = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0]        bus_addr = '0;
  logic [7:0]         bus_wdata = '0;
  logic [7:0]         bus_rdata;
  logic [NCHIP-1:0]   chip_sel;
  logic               chip_we;
  logic [4:0]         chip_reg;
  logic [7:0]         chip_wdata;
  logic [NCHIP*8-1:0] chip_rdata;

  int errors = 0, checks = 0, tb_mode = 0;
  int hits [NCHIP][32];
  bit done = 0;

  always #2 clk = ~clk;

  multi_chip_remap u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chip_sel(chip_sel), .chip_we(chip_we), .chip_reg(chip_reg),
    .chip_wdata(chip_wdata), .chip_rdata(chip_rdata)
  );

  function automatic logic [7:0] chip_byte(input int n);
    return 8'((n * 9 + 17) & 255);
  endfunction

  // behavioural reference of the layouts
  function automatic void ref_map(input int m, input int o, output int c, output int r, output bit ok);
    c = 0; r = 0; ok = 0;
    if (m == 1) begin r = o / 32; c = o % 32; ok = 1; end
    else if (m == 2) begin
      if (o < 168) begin c = (o % 24) / 3; r = 7 * ((o % 24) % 3) + o / 24; ok = 1; end
      else if (o < 232) begin c = (o - 168) % 8; r = 21 + (o - 168) / 8; ok = 1; end
    end else begin c = o / 32; r = o % 32; ok = 1; end
    if (r > 28 || c >= NCHIP || o == 1023) ok = 0;
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // one bus cycle, checked 1 ns after inputs settle; model mode moves at the edge
  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d, input string req);
    int c, r, o, sel_i;
    bit ok, inwin;
    logic [NCHIP-1:0] e_sel;
    logic [7:0] e_rd;
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    inwin = (a[15:10] == 6'b110101);
    o = int'(a[9:0]);
    ref_map(tb_mode, o, c, r, ok);
    if (!inwin) ok = 0;
    e_sel = ok ? (NCHIP'(1) << c) : '0;
    if (ok) e_rd = chip_byte(c);
    else if (inwin && o == 1023) e_rd = 8'(tb_mode);
    else e_rd = 8'hFF;
    checks++;
    if (chip_sel !== e_sel) fail(req, "chip_sel", int'(chip_sel), int'(e_sel));
    else if (chip_reg !== (ok ? 5'(r) : 5'd0)) fail(req, "chip_reg", int'(chip_reg), ok ? r : 0);
    else if (chip_we !== (ok && we)) fail(req, "chip_we", int'(chip_we), int'(ok && we));
    else if (!we && bus_rdata !== e_rd) fail(req, "rdata", int'(bus_rdata), int'(e_rd));
    else if (we && ok && chip_wdata !== d) fail(req, "wdata", int'(chip_wdata), int'(d));
    if (!we) begin
      sel_i = -1;
      for (int k = 0; k < NCHIP; k++) if (chip_sel[k]) sel_i = k;
      if (sel_i >= 0) hits[sel_i][chip_reg]++;
    end
    @(posedge clk);
    if (inwin && we && o == 1023) tb_mode = int'(d[1:0]);
    #1 bus_valid = 0;
  endtask

  task automatic sweep_mode(input int m, input string req);
    int nch;
    for (int c = 0; c < NCHIP; c++) for (int r = 0; r < 32; r++) hits[c][r] = 0;
    access(1, 16'hD7FF, 8'hFC | 8'(m), "R7");
    access(0, 16'hD7FF, 8'h00, "R7");
    for (int o = 0; o < 1024; o++) access(0, 16'hD400 + 16'(o), 8'h00, req);
    nch = (m == 2) ? 8 : NCHIP;
    for (int c = 0; c < NCHIP; c++)
      for (int r = 0; r < 32; r++) begin
        int e;
        e = (c < nch && r <= 28) ? 1 : 0;
        checks++;
        if (hits[c][r] != e) fail("R11", $sformatf("pair %0d/%0d count", c, r), hits[c][r], e);
      end
  endtask

  initial begin
    for (int n = 0; n < NCHIP; n++) chip_rdata[n*8 +: 8] = chip_byte(n);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    access(0, 16'hD7FF, 8'h00, "R1");
    access(0, 16'hD421, 8'h00, "R1");
    // R2, R10, R6: linear writes and reads
    access(1, 16'hD400, 8'hA5, "R2");
    access(1, 16'hD7BC, 8'h3C, "R10");
    access(0, 16'hD5E7, 8'h00, "R10");
    access(1, 16'hD41D, 8'h77, "R6");
    access(0, 16'hD43F, 8'h00, "R6");
    // R9: outside the window
    access(1, 16'hD3FF, 8'h11, "R9");
    access(0, 16'hD800, 8'h00, "R9");
    access(0, 16'h0000, 8'h00, "R9");
    // R7: mode write then an access in the very next cycle
    access(1, 16'hD7FF, 8'h01, "R7");
    access(0, 16'hD401, 8'h00, "R3");
    access(1, 16'hD7FF, 8'h02, "R7");
    access(1, 16'hD418, 8'h5A, "R4");
    access(0, 16'hD4A8, 8'h00, "R5");
    access(0, 16'hD4E8, 8'h00, "R5");
    access(1, 16'hD7FF, 8'h00, "R7");
    access(0, 16'hD418, 8'h00, "R2");
    // exhaustive sweeps, all four codes
    sweep_mode(0, "R2");
    sweep_mode(1, "R3");
    sweep_mode(2, "R4");
    sweep_mode(3, "R8");
    // R5 & R6 in voice mode with writes to tail and shared slots
    access(1, 16'hD7FF, 8'h02, "R7");
    access(1, 16'hD4E7, 8'h99, "R5");
    access(1, 16'hD4E8, 8'h99, "R6");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule